// File: doc/BRIEF.md
# PHY Strap Configuration and Carrier Sense

This block captures a PHY's configuration straps once, on the clock edge after reset is released. After that edge the strap pins have no effect until the next reset. A 4-bit operating-mode strap is decoded into four settings: whether auto-negotiation is enabled, which abilities are advertised, the speed and duplex the control register holds, and whether a fiber link is forced. The remaining single-bit straps become fixed bits in two vendor-range configuration registers. These are the repeater/node select, three bypass selects for the 100 Mb/s path, and a serial/nibble select.

The block also registers a carrier-sense output from receive and transmit activity. Transmit activity is masked when the repeater strap is set or full duplex is configured. A link-status output follows a status-register bit that is sampled from a link indication input. A combinational register read port exposes the latched state, so that surrounding logic and tests can check it.

Top module: `phy_strap_cfg`

## Requirements
- R1: Straps are captured on the first rising clock edge with rstN high; strap pin changes after that edge alter no register or output until rstN is asserted again.
- R2: Auto-negotiation modes set register 0 bit 12. Register 4 holds the abilities: bit 10 pause, bit 8 100FD, bit 7 100HD, bit 6 10FD, bit 5 10HD. The codes are: 0000 all with pause; 0001 all without pause; 0010 100FD with pause; 0011 100FD and 100HD; 0100 10FD with pause; 0101 10FD and 10HD; 1111 100HD and 10HD. Register 0 bit 13 is set when any 100 ability is advertised, and bit 8 when any full-duplex ability is advertised.
- R3: Codes 0110, 0111, 1000 and 1001 clear register 0 bit 12 and register 4, and force 100FD, 100HD, 10FD and 10HD respectively. Register 0 bit 13 is speed 100 and bit 8 is full duplex. Codes 1010 and 1011 force 100 FD and 100 HD on fiber, which is shown by register 16 bit 0 and the forceFiber output.
- R4: Codes 1100, 1101 and 1110 behave exactly as code 0000.
- R5: Register 16 holds the straps at these bits: bit 15 code-group bypass, bit 14 scrambler bypass, bit 13 alignment bypass, bit 11 repeater select.
- R6: Register 18 bit 10 holds the serial strap. The serialMode output is high only when that bit is set and the speed is 10 Mb/s.
- R7: crsOut is registered with one clock of latency. It is high after any cycle with rxActive high. A cycle with only txActive high drives crsOut high only in node mode with half duplex.
- R8: Register 1 bit 2 samples linkIn every clock, and linkStatusOut always equals that bit.
- R9: While rstN is low, every output is 0 and every register reads 0. Addresses other than 0, 1, 4, 16 and 18 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapMode | input | 4 | Operating-mode strap |
| strapRepeater | input | 1 | Repeater (1) / node (0) strap |
| strapAlignBypass | input | 1 | Alignment bypass strap |
| strapScrBypass | input | 1 | Scrambler bypass strap |
| strapCodeBypass | input | 1 | Code-group bypass strap |
| strapSerial | input | 1 | Serial (1) / nibble (0) strap |
| rxActive | input | 1 | Receive activity |
| txActive | input | 1 | Transmit activity |
| linkIn | input | 1 | Link indication from the line side |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | 16 | Register read data |
| crsOut | output | 1 | Carrier sense |
| linkStatusOut | output | 1 | Link status (register 1 bit 2) |
| anEnable | output | 1 | Auto-negotiation enabled |
| advCaps | output | 5 | Advertised abilities {pause,100FD,100HD,10FD,10HD} |
| speed100 | output | 1 | Configured speed is 100 Mb/s |
| fullDuplex | output | 1 | Configured duplex is full |
| forceFiber | output | 1 | Forced fiber mode |
| serialMode | output | 1 | 10 Mb/s serial transfer in effect |

## Verification
Strap capture and carrier-sense generation share a clock edge. On the release edge, crsOut is computed from the duplex and repeater settings that hold before the load. From the next edge on, it uses the freshly latched settings. The bench holds txActive high across reset release in a full-duplex mode. It expects crsOut high for the release cycle and low from the following cycle on, which shows the new mask takes effect exactly one edge after capture.

// File: rtl/strapcfg_pkg.sv
package strapcfg_pkg;

  localparam int MODE_W  = 4;
  localparam int ADV_W   = 5;
  localparam int DATA_W  = 16;

  localparam int REG_CTRL   = 0;
  localparam int REG_STAT   = 1;
  localparam int REG_ADV    = 4;
  localparam int REG_STRAPA = 16;
  localparam int REG_STRAPB = 18;

  // advertised ability bit order {pause, 100FD, 100HD, 10FD, 10HD}
  localparam logic [ADV_W-1:0] ADV_NONE = 5'b00000;

  typedef struct packed {
    logic loadStraps;
    logic cfgValid;
  } ctrl_strobe_t;

  typedef struct packed {
    logic              anEnable;
    logic [ADV_W-1:0]  adv;
    logic              speed100;
    logic              fullDuplex;
    logic              fiber;
  } mode_cfg_t;

  function automatic mode_cfg_t makeAn(input logic [ADV_W-1:0] adv);
    mode_cfg_t c;
    c.anEnable   = 1'b1;
    c.adv        = adv;
    c.speed100   = adv[3] | adv[2];
    c.fullDuplex = adv[3] | adv[1];
    c.fiber      = 1'b0;
    return c;
  endfunction

  function automatic mode_cfg_t makeForced(input logic spd, input logic fd, input logic fib);
    mode_cfg_t c;
    c.anEnable   = 1'b0;
    c.adv        = ADV_NONE;
    c.speed100   = spd;
    c.fullDuplex = fd;
    c.fiber      = fib;
    return c;
  endfunction

  function automatic mode_cfg_t decodeMode(input logic [MODE_W-1:0] code);
    mode_cfg_t c;
    case (code)
      4'b0001: c = makeAn(5'b01111);
      4'b0010: c = makeAn(5'b11000);
      4'b0011: c = makeAn(5'b01100);
      4'b0100: c = makeAn(5'b10010);
      4'b0101: c = makeAn(5'b00011);
      4'b0110: c = makeForced(1'b1, 1'b1, 1'b0);
      4'b0111: c = makeForced(1'b1, 1'b0, 1'b0);
      4'b1000: c = makeForced(1'b0, 1'b1, 1'b0);
      4'b1001: c = makeForced(1'b0, 1'b0, 1'b0);
      4'b1010: c = makeForced(1'b1, 1'b1, 1'b1);
      4'b1011: c = makeForced(1'b1, 1'b0, 1'b1);
      4'b1111: c = makeAn(5'b00101);
      default: c = makeAn(5'b11111); // 0000 and reserved codes
    endcase
    return c;
  endfunction

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strapcfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output ctrl_strobe_t strobe
);

  logic captured;

  always_ff @(posedge clk) begin
    if (!rstN) captured <= 1'b0;
    else       captured <= 1'b1;
  end

  always_comb begin
    strobe.loadStraps = rstN & ~captured;
    strobe.cfgValid   = captured;
  end

  // R1
  cfg_valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgValid |=> strobe.cfgValid && !strobe.loadStraps);

  // R1
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStraps |=> !strobe.loadStraps);

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strapcfg_pkg::*;
#(
  parameter int ADDR_W = 5
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic [MODE_W-1:0]   strapMode,
  input  logic                strapRepeater,
  input  logic                strapAlignBypass,
  input  logic                strapScrBypass,
  input  logic                strapCodeBypass,
  input  logic                strapSerial,
  input  logic                rxActive,
  input  logic                txActive,
  input  logic                linkIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                crsOut,
  output logic                linkStatusOut,
  output logic                anEnable,
  output logic [ADV_W-1:0]    advCaps,
  output logic                speed100,
  output logic                fullDuplex,
  output logic                forceFiber,
  output logic                serialMode
);

  mode_cfg_t cfgQ;
  logic      repQ, alignQ, scrQ, codeQ, serQ;
  logic      linkQ, crsQ;
  logic      txMasked;

  assign txMasked = repQ | cfgQ.fullDuplex;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      repQ   <= 1'b0;
      alignQ <= 1'b0;
      scrQ   <= 1'b0;
      codeQ  <= 1'b0;
      serQ   <= 1'b0;
      linkQ  <= 1'b0;
      crsQ   <= 1'b0;
    end else begin
      if (strobe.loadStraps) begin
        cfgQ   <= decodeMode(strapMode);
        repQ   <= strapRepeater;
        alignQ <= strapAlignBypass;
        scrQ   <= strapScrBypass;
        codeQ  <= strapCodeBypass;
        serQ   <= strapSerial;
      end
      linkQ <= linkIn;
      crsQ  <= rxActive | (txActive & ~txMasked);
    end
  end

  assign crsOut        = crsQ;
  assign linkStatusOut = linkQ;
  assign anEnable      = cfgQ.anEnable;
  assign advCaps       = cfgQ.adv;
  assign speed100      = cfgQ.speed100;
  assign fullDuplex    = cfgQ.fullDuplex;
  assign forceFiber    = cfgQ.fiber;
  assign serialMode    = serQ & ~cfgQ.speed100;

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(REG_CTRL)) begin
      rdData[13] = cfgQ.speed100;
      rdData[12] = cfgQ.anEnable;
      rdData[8]  = cfgQ.fullDuplex;
    end else if (rdAddr == ADDR_W'(REG_STAT)) begin
      rdData[2]  = linkQ;
    end else if (rdAddr == ADDR_W'(REG_ADV)) begin
      rdData[10]  = cfgQ.adv[4];
      rdData[8:5] = cfgQ.adv[3:0];
    end else if (rdAddr == ADDR_W'(REG_STRAPA)) begin
      rdData[15] = codeQ;
      rdData[14] = scrQ;
      rdData[13] = alignQ;
      rdData[11] = repQ;
      rdData[0]  = cfgQ.fiber;
    end else if (rdAddr == ADDR_W'(REG_STRAPB)) begin
      rdData[10] = serQ;
    end
  end

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStraps |=> $stable(cfgQ) && $stable({repQ, alignQ, scrQ, codeQ, serQ}));

  // R7
  crs_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |=> crsOut);

  // R7
  crs_tx_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && txMasked) |=> !crsOut);

  // R7
  crs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && !txActive) |=> !crsOut);

  // R8
  link_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> linkStatusOut == $past(linkIn));

  // R3
  fiber_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceFiber |-> !anEnable && advCaps == ADV_NONE && speed100);

endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
  import strapcfg_pkg::*;
#(
  parameter int ADDR_W = 5
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   strapMode,
  input  logic                strapRepeater,
  input  logic                strapAlignBypass,
  input  logic                strapScrBypass,
  input  logic                strapCodeBypass,
  input  logic                strapSerial,
  input  logic                rxActive,
  input  logic                txActive,
  input  logic                linkIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                crsOut,
  output logic                linkStatusOut,
  output logic                anEnable,
  output logic [ADV_W-1:0]    advCaps,
  output logic                speed100,
  output logic                fullDuplex,
  output logic                forceFiber,
  output logic                serialMode
);

  ctrl_strobe_t strobe;

  strap_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  strap_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .strapMode        (strapMode),
    .strapRepeater    (strapRepeater),
    .strapAlignBypass (strapAlignBypass),
    .strapScrBypass   (strapScrBypass),
    .strapCodeBypass  (strapCodeBypass),
    .strapSerial      (strapSerial),
    .rxActive         (rxActive),
    .txActive         (txActive),
    .linkIn           (linkIn),
    .rdAddr           (rdAddr),
    .rdData           (rdData),
    .crsOut           (crsOut),
    .linkStatusOut    (linkStatusOut),
    .anEnable         (anEnable),
    .advCaps          (advCaps),
    .speed100         (speed100),
    .fullDuplex       (fullDuplex),
    .forceFiber       (forceFiber),
    .serialMode       (serialMode)
  );

  // R8
  always_comb begin
    if (rstN && rdAddr == ADDR_W'(REG_STAT))
      link_read_chk: assert (rdData[2] == linkStatusOut);
  end

  // R6
  serial_at_ten_chk: assert property (@(posedge clk) disable iff (!rstN)
    serialMode |-> !speed100 && rdData == rdData);

endmodule

// File: tb/sim_phy_strap_cfg.sv
module sim_phy_strap_cfg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  strapMode = '0;
  logic        strapRepeater = 0, strapAlignBypass = 0, strapScrBypass = 0;
  logic        strapCodeBypass = 0, strapSerial = 0;
  logic        rxActive = 0, txActive = 0, linkIn = 0;
  logic [4:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        crsOut, linkStatusOut, anEnable, speed100, fullDuplex, forceFiber, serialMode;
  logic [4:0]  advCaps;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phy_strap_cfg u0 (.*);

  // {an, adv[4:0], spd, fd, fiber} per mode code
  localparam logic [8:0] VEC [16] = '{
    9'b1_11111_1_1_0, 9'b1_01111_1_1_0, 9'b1_11000_1_1_0, 9'b1_01100_1_1_0,
    9'b1_10010_0_1_0, 9'b1_00011_0_1_0, 9'b0_00000_1_1_0, 9'b0_00000_1_0_0,
    9'b0_00000_0_1_0, 9'b0_00000_0_0_0, 9'b0_00000_1_1_1, 9'b0_00000_1_0_1,
    9'b1_11111_1_1_0, 9'b1_11111_1_1_0, 9'b1_11111_1_1_0, 9'b1_00101_1_0_0
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [4:0] a, output logic [15:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic applyReset(input logic [3:0] m, input logic rep, input logic al,
                            input logic sc, input logic cb, input logic se);
    rstN = 0;
    strapMode = m; strapRepeater = rep; strapAlignBypass = al;
    strapScrBypass = sc; strapCodeBypass = cb; strapSerial = se;
    repeat (2) tick();
    rstN = 1;
    tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] exp0, exp4;
    @(negedge clk);

    // R9: reset state with straps and activity all high
    strapMode = 4'hA; strapRepeater = 1; strapAlignBypass = 1; strapScrBypass = 1;
    strapCodeBypass = 1; strapSerial = 1; rxActive = 1; linkIn = 1;
    repeat (3) tick();
    chk("R9 crsOut in reset", 16'(crsOut), 16'd0);
    chk("R9 linkStatusOut in reset", 16'(linkStatusOut), 16'd0);
    chk("R9 outputs in reset", 16'({anEnable, advCaps, speed100, fullDuplex, forceFiber, serialMode}), 16'd0);
    readReg(5'd16, d); chk("R9 reg16 in reset", d, 16'h0000);
    readReg(5'd18, d); chk("R9 reg18 in reset", d, 16'h0000);
    rxActive = 0; linkIn = 0;

    // mode table walk: R2 / R3 / R4
    for (int i = 0; i < 16; i++) begin
      string tag;
      logic [8:0] v;
      v = VEC[i];
      if (i >= 12 && i <= 14) tag = "R4";
      else if (i >= 6 && i <= 11) tag = "R3";
      else tag = "R2";
      applyReset(4'(i), 0, 0, 0, 0, 0);
      exp0 = '0; exp0[13] = v[2]; exp0[12] = v[8]; exp0[8] = v[1];
      exp4 = '0; exp4[10] = v[7]; exp4[8:5] = v[6:3];
      readReg(5'd0, d);  chk($sformatf("%s mode %0d reg0", tag, i), d, exp0);
      readReg(5'd4, d);  chk($sformatf("%s mode %0d reg4", tag, i), d, exp4);
      readReg(5'd16, d); chk($sformatf("%s mode %0d fiber bit", tag, i), d, {15'd0, v[0]});
      chk($sformatf("%s mode %0d outputs", tag, i),
          16'({anEnable, advCaps, speed100, fullDuplex, forceFiber}), 16'(v));
    end

    // R1: straps changed after capture are ignored
    applyReset(4'b0110, 0, 0, 0, 0, 0);
    strapMode = 4'b0000; strapRepeater = 1; strapCodeBypass = 1; strapSerial = 1;
    repeat (4) tick();
    readReg(5'd0, d);  chk("R1 reg0 after strap change", d, 16'h2100);
    readReg(5'd16, d); chk("R1 reg16 after strap change", d, 16'h0000);
    readReg(5'd18, d); chk("R1 reg18 after strap change", d, 16'h0000);
    // and recaptured by a new reset
    applyReset(strapMode, strapRepeater, 0, 0, strapCodeBypass, 0);
    readReg(5'd0, d);  chk("R1 reg0 recaptured", d, 16'h3100);

    // R5: bypass and repeater bits
    applyReset(4'b0000, 1, 0, 1, 0, 0);
    readReg(5'd16, d); chk("R5 reg16 rep+scr", d, 16'h4800);
    applyReset(4'b0000, 0, 1, 0, 1, 0);
    readReg(5'd16, d); chk("R5 reg16 align+code", d, 16'hA000);

    // R6: serial only at 10 Mb/s
    applyReset(4'b1000, 0, 0, 0, 0, 1);
    chk("R6 serialMode at 10", 16'(serialMode), 16'd1);
    readReg(5'd18, d); chk("R6 reg18 at 10", d, 16'h0400);
    applyReset(4'b0110, 0, 0, 0, 0, 1);
    chk("R6 serialMode at 100", 16'(serialMode), 16'd0);
    readReg(5'd18, d); chk("R6 reg18 at 100", d, 16'h0400);

    // R7: node, half duplex: tx drives crs with one clock latency
    applyReset(4'b1001, 0, 0, 0, 0, 0);
    txActive = 1; #0.5;
    chk("R7 crs before edge", 16'(crsOut), 16'd0);
    tick();
    chk("R7 tx node HD", 16'(crsOut), 16'd1);
    txActive = 0; tick();
    chk("R7 idle", 16'(crsOut), 16'd0);
    // full duplex node: tx masked, rx passes
    applyReset(4'b1000, 0, 0, 0, 0, 0);
    txActive = 1; tick();
    chk("R7 tx node FD", 16'(crsOut), 16'd0);
    rxActive = 1; tick();
    chk("R7 rx node FD", 16'(crsOut), 16'd1);
    rxActive = 0; txActive = 0; tick();
    // repeater half duplex: tx masked
    applyReset(4'b1001, 1, 0, 0, 0, 0);
    txActive = 1; tick();
    chk("R7 tx repeater HD", 16'(crsOut), 16'd0);
    txActive = 0; tick();

    // R7/R1 same edge: tx held across release into full duplex
    rstN = 0; strapMode = 4'b0110; strapRepeater = 0;
    txActive = 1;
    repeat (2) tick();
    rstN = 1; tick();
    chk("R7 crs on capture edge uses pre-load mask", 16'(crsOut), 16'd1);
    tick();
    chk("R7 crs after capture uses new mask", 16'(crsOut), 16'd0);
    txActive = 0;

    // R8: link status
    linkIn = 1; #0.5;
    chk("R8 link before edge", 16'(linkStatusOut), 16'd0);
    tick();
    chk("R8 link high", 16'(linkStatusOut), 16'd1);
    readReg(5'd1, d); chk("R8 reg1 high", d, 16'h0004);
    linkIn = 0; tick();
    chk("R8 link low", 16'(linkStatusOut), 16'd0);

    // R9: unmapped address
    readReg(5'd7, d); chk("R9 unmapped read", d, 16'h0000);

    finishRun();
  end

endmodule